// File: doc/BRIEF.md
# Operand-Capturing Reservation Station Pool

This block holds a small set of reservation stations that sit in front of a single execution unit. When an operation is issued it takes a free station, and each of its two operands (the sink operand and the source operand) arrives either as a value or as the tag of the unit that will produce it. Stations whose operands are still owed watch the result broadcast bus every cycle. When the bus carries the tag they are waiting for, they take the data straight off the bus.

When a station has both operands it becomes ready. The pool offers one ready station at a time to the execution unit. The offer goes to the station that became ready earliest, not to the oldest one in issue order. Each station has a fixed identifier, which also names its result. A station stays busy after dispatch until its own identifier appears on the broadcast bus, and is free again on the next cycle. A pool configured for the add unit has three stations; one configured for the multiply/divide unit has two.

Top module: `rs_pool`

## Requirements
- R1: Station k (k counting from 0) carries the fixed identifier BASE_TAG+k. `alloc_tag` shows the identifier of the station that the next allocation will take, which is always the lowest-numbered free station. `disp_tag` shows the identifier of the station being offered.
- R2: `full` is high exactly when no station is free. An allocation presented while `full` is high changes no station.
- R3: An operand given as a value at allocation (its wait flag low) is delivered unchanged on `disp_a`/`disp_b`, together with the operation code on `disp_op`.
- R4: A waiting operand takes `bus_data` on the clock edge where `bus_valid` is high and `bus_tag` equals its awaited tag. A broadcast carrying any other tag leaves it waiting.
- R5: If an operand is allocated with its wait flag high and the bus broadcasts that same tag in the same cycle, the bus data is captured and not lost.
- R6: A station raises `disp_valid` in the cycle after its last operand becomes present, and not before both operands are present.
- R7: Among ready stations, the one that became ready in the earliest cycle is offered first.
- R8: When several stations became ready in the same cycle, the lowest identifier is offered first.
- R9: A station that is accepted (`disp_valid` and `disp_ready` both high) is never offered again. It becomes free in the cycle after `bus_valid` is high with `bus_tag` equal to its identifier.
- R10: While `disp_valid` is high and `disp_ready` is low, the offered tag, operation code and operands hold steady.
- R11: After reset, all stations are free, `full` and `disp_valid` are low, and `alloc_tag` equals BASE_TAG.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| alloc_valid | input | 1 | Issue an operation into the pool |
| alloc_op | input | OP_W | Operation code of the issued operation |
| alloc_a_wait | input | 1 | Sink operand is owed by a producer |
| alloc_a_tag | input | TAG_W | Producer tag of the sink operand |
| alloc_a_data | input | DATA_W | Sink operand value |
| alloc_b_wait | input | 1 | Source operand is owed by a producer |
| alloc_b_tag | input | TAG_W | Producer tag of the source operand |
| alloc_b_data | input | DATA_W | Source operand value (register or load-buffer path) |
| full | output | 1 | No station free; allocation refused |
| alloc_tag | output | TAG_W | Identifier the next allocation receives |
| bus_valid | input | 1 | Result broadcast present |
| bus_tag | input | TAG_W | Tag of the broadcasting producer |
| bus_data | input | DATA_W | Broadcast result value |
| disp_valid | output | 1 | A ready station is offered to the execution unit |
| disp_ready | input | 1 | Execution unit accepts the offer |
| disp_op | output | OP_W | Operation code of the offered station |
| disp_tag | output | TAG_W | Identifier of the offered station |
| disp_a | output | DATA_W | Sink operand of the offered station |
| disp_b | output | DATA_W | Source operand of the offered station |

## Verification
The bench builds the pool with three stations, base identifier 10, 16-bit data and a 4-bit operation code, which is the add-unit configuration. With three stations, one bench can drive the pool to full, refuse an allocation while full, and produce both cases of the ordering rule: a higher-numbered station that became ready first and is offered ahead of a lower one, and two stations released by one broadcast in the same cycle. A 16-bit data width keeps the captured values easy to tell apart, and it has no effect on the tag and ordering logic.

// File: rtl/rs_pkg.sv
// Package rs_pkg
// Shared types of the reservation station pool.
// Assumes: nothing beyond IEEE 1800-2017.
package rs_pkg;

    // Life of one station: free, collecting operands, dispatched awaiting result broadcast
    typedef enum logic [1:0] {
        ST_FREE   = 2'd0,
        ST_WAIT   = 2'd1,
        ST_ISSUED = 2'd2
    } st_e;

endpackage

// File: rtl/rs_operand_slot.sv
// Module rs_operand_slot
// One operand slot of a station. The slot holds either a value or the tag
// of the producer that owes the value, and it snoops the broadcast bus.
// Assumes: load is high for one cycle when the owning station is allocated;
// a slot that is already present ignores the bus.
module rs_operand_slot #(
    parameter int TAG_W  = 4,
    parameter int DATA_W = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic              in_wait,
    input  logic [TAG_W-1:0]  in_tag,
    input  logic [DATA_W-1:0] in_data,
    input  logic              bus_valid,
    input  logic [TAG_W-1:0]  bus_tag,
    input  logic [DATA_W-1:0] bus_data,
    output logic              have,
    output logic              have_nxt,
    output logic [DATA_W-1:0] data
);

    logic              have_q;
    logic [TAG_W-1:0]  tag_q;
    logic [DATA_W-1:0] data_q;
    logic [TAG_W-1:0]  tag_n;
    logic [DATA_W-1:0] data_n;
    logic              hit_in;
    logic              hit_q;

    // Compare the bus tag against the incoming tag and the held tag
    always_comb begin
        hit_in = bus_valid && (bus_tag == in_tag);
        hit_q  = bus_valid && (bus_tag == tag_q);
    end

    // Next slot contents: allocation wins, otherwise snoop a pending tag
    always_comb begin
        have_nxt = have_q;
        tag_n    = tag_q;
        data_n   = data_q;
        if (load) begin
            tag_n = in_tag;
            if (!in_wait) begin
                have_nxt = 1'b1;
                data_n   = in_data;
            end else if (hit_in) begin
                have_nxt = 1'b1;
                data_n   = bus_data;
            end else begin
                have_nxt = 1'b0;
            end
        end else if (!have_q && hit_q) begin
            have_nxt = 1'b1;
            data_n   = bus_data;
        end
    end

    // Slot state registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            have_q <= 1'b0;
            tag_q  <= '0;
            data_q <= '0;
        end else begin
            have_q <= have_nxt;
            tag_q  <= tag_n;
            data_q <= data_n;
        end
    end

    assign have = have_q;
    assign data = data_q;

    // R4: a waiting slot that sees its tag holds the bus data afterwards
    a_r4_snoop_capture: assert property (@(posedge clk) disable iff (!rst_n)
        (!have_q && !load && bus_valid && bus_tag == tag_q)
        |=> (have_q && data_q == $past(bus_data)));

    // R5: a tag broadcast during allocation is not lost
    a_r5_alloc_catch: assert property (@(posedge clk) disable iff (!rst_n)
        (load && in_wait && bus_valid && bus_tag == in_tag)
        |=> (have_q && data_q == $past(bus_data)));

endmodule

// File: rtl/rs_first_free.sv
// Module rs_first_free
// Finds the lowest-numbered free station for allocation.
// Assumes: N >= 1.
module rs_first_free #(
    parameter int N     = 3,
    parameter int IDX_W = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0]     free,
    output logic [N-1:0]     pick,
    output logic [IDX_W-1:0] idx,
    output logic             any
);

    // Scan from the top so the lowest free index wins
    always_comb begin
        pick = '0;
        idx  = '0;
        any  = 1'b0;
        for (int i = N - 1; i >= 0; i--) begin
            if (free[i]) begin
                pick    = '0;
                pick[i] = 1'b1;
                idx     = IDX_W'(i);
                any     = 1'b1;
            end
        end
    end

endmodule

// File: rtl/rs_age_arb.sv
// Module rs_age_arb
// Ready-order arbiter. An age matrix records which ready station became
// ready before which other station. The grant goes to the earliest ready
// station; stations made ready in the same cycle are ranked by lowest index.
// Assumes: a station stays ready until it is granted and fired; nxt_ready
// is the ready vector of the next cycle.
module rs_age_arb #(
    parameter int N = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] ready,
    input  logic [N-1:0] nxt_ready,
    input  logic         fire,
    output logic [N-1:0] grant,
    output logic         any
);

    // older_q[j][i] set: station j became ready before station i
    logic [N-1:0] older_q [N];
    logic [N-1:0] older_n [N];
    logic [N-1:0] still;
    logic [N-1:0] fresh;
    logic [N-1:0] unblocked;

    // Grant: a ready station that no other ready station is older than
    always_comb begin
        for (int i = 0; i < N; i++) begin
            unblocked[i] = ready[i];
            for (int j = 0; j < N; j++) begin
                if (j != i && ready[j] && older_q[j][i]) begin
                    unblocked[i] = 1'b0;
                end
            end
        end
        grant = '0;
        any   = 1'b0;
        for (int i = N - 1; i >= 0; i--) begin
            if (unblocked[i]) begin
                grant    = '0;
                grant[i] = 1'b1;
                any      = 1'b1;
            end
        end
    end

    // Split next-cycle ready stations into carried-over and newly ready
    always_comb begin
        for (int i = 0; i < N; i++) begin
            still[i] = ready[i] && !(fire && grant[i]);
            fresh[i] = nxt_ready[i] && !still[i];
        end
    end

    // Newly ready stations rank behind all carried-over ones, ties by index
    always_comb begin
        for (int j = 0; j < N; j++) begin
            for (int i = 0; i < N; i++) begin
                if (fresh[i]) begin
                    older_n[j][i] = still[j] || (fresh[j] && (j < i));
                end else if (fresh[j]) begin
                    older_n[j][i] = 1'b0;
                end else begin
                    older_n[j][i] = older_q[j][i];
                end
            end
        end
    end

    // Age matrix registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int j = 0; j < N; j++) begin
                older_q[j] <= '0;
            end
        end else begin
            for (int j = 0; j < N; j++) begin
                older_q[j] <= older_n[j];
            end
        end
    end

    // R7: at most one station granted, and only a ready one
    a_r7_single_grant: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant) && ((grant & ~ready) == '0));

    // R8: with no ready station, nothing is granted
    a_r8_idle_no_grant: assert property (@(posedge clk) disable iff (!rst_n)
        (ready == '0) |-> !any);

endmodule

// File: rtl/rs_pool.sv
// Module rs_pool
// Pool of operand-capturing reservation stations in front of one execution
// unit. Allocates into the lowest free station, captures owed operands from
// the broadcast bus, and offers ready stations in ready order.
// Assumes: a station's own identifier is broadcast only after it was
// dispatched; the execution unit takes one offer per disp_ready cycle.
module rs_pool #(
    parameter int NUM_ST   = 3,
    parameter int TAG_W    = 4,
    parameter int DATA_W   = 64,
    parameter int OP_W     = 4,
    parameter int BASE_TAG = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              alloc_valid,
    input  logic [OP_W-1:0]   alloc_op,
    input  logic              alloc_a_wait,
    input  logic [TAG_W-1:0]  alloc_a_tag,
    input  logic [DATA_W-1:0] alloc_a_data,
    input  logic              alloc_b_wait,
    input  logic [TAG_W-1:0]  alloc_b_tag,
    input  logic [DATA_W-1:0] alloc_b_data,
    output logic              full,
    output logic [TAG_W-1:0]  alloc_tag,
    input  logic              bus_valid,
    input  logic [TAG_W-1:0]  bus_tag,
    input  logic [DATA_W-1:0] bus_data,
    output logic              disp_valid,
    input  logic              disp_ready,
    output logic [OP_W-1:0]   disp_op,
    output logic [TAG_W-1:0]  disp_tag,
    output logic [DATA_W-1:0] disp_a,
    output logic [DATA_W-1:0] disp_b
);
    import rs_pkg::*;

    localparam int IDX_W = (NUM_ST > 1) ? $clog2(NUM_ST) : 1;

    logic [NUM_ST-1:0] free_vec;
    logic [NUM_ST-1:0] pick;
    logic [IDX_W-1:0]  pick_idx;
    logic              pick_any;
    logic [NUM_ST-1:0] ready_vec;
    logic [NUM_ST-1:0] nxt_ready_vec;
    logic [NUM_ST-1:0] grant;
    logic              grant_any;
    logic              alloc_fire;
    logic              disp_fire;

    logic [OP_W-1:0]   op_arr [NUM_ST];
    logic [DATA_W-1:0] a_arr  [NUM_ST];
    logic [DATA_W-1:0] b_arr  [NUM_ST];

    rs_first_free #(.N(NUM_ST), .IDX_W(IDX_W)) u_pick (
        .free (free_vec),
        .pick (pick),
        .idx  (pick_idx),
        .any  (pick_any)
    );

    // Edge handshakes and allocation status
    always_comb begin
        full       = !pick_any;
        alloc_fire = alloc_valid && pick_any;
        alloc_tag  = TAG_W'(BASE_TAG) + TAG_W'(pick_idx);
        disp_fire  = disp_valid && disp_ready;
    end

    for (genvar k = 0; k < NUM_ST; k++) begin : g_st
        localparam logic [TAG_W-1:0] ID = TAG_W'(BASE_TAG + k);

        st_e             st_q;
        st_e             st_n;
        logic [OP_W-1:0] op_q;
        logic            load;
        logic            a_have;
        logic            a_have_n;
        logic            b_have;
        logic            b_have_n;

        // This station is the allocation target this cycle
        assign load = alloc_fire && pick[k];

        rs_operand_slot #(.TAG_W(TAG_W), .DATA_W(DATA_W)) u_a (
            .clk       (clk),
            .rst_n     (rst_n),
            .load      (load),
            .in_wait   (alloc_a_wait),
            .in_tag    (alloc_a_tag),
            .in_data   (alloc_a_data),
            .bus_valid (bus_valid),
            .bus_tag   (bus_tag),
            .bus_data  (bus_data),
            .have      (a_have),
            .have_nxt  (a_have_n),
            .data      (a_arr[k])
        );

        rs_operand_slot #(.TAG_W(TAG_W), .DATA_W(DATA_W)) u_b (
            .clk       (clk),
            .rst_n     (rst_n),
            .load      (load),
            .in_wait   (alloc_b_wait),
            .in_tag    (alloc_b_tag),
            .in_data   (alloc_b_data),
            .bus_valid (bus_valid),
            .bus_tag   (bus_tag),
            .bus_data  (bus_data),
            .have      (b_have),
            .have_nxt  (b_have_n),
            .data      (b_arr[k])
        );

        // Station life cycle: allocate, dispatch, release on own broadcast
        always_comb begin
            st_n = st_q;
            unique case (st_q)
                ST_FREE:   if (load) st_n = ST_WAIT;
                ST_WAIT:   if (disp_fire && grant[k]) st_n = ST_ISSUED;
                ST_ISSUED: if (bus_valid && bus_tag == ID) st_n = ST_FREE;
                default:   st_n = ST_FREE;
            endcase
        end

        // Status vectors seen by the picker and the arbiter
        always_comb begin
            free_vec[k]      = (st_q == ST_FREE);
            ready_vec[k]     = (st_q == ST_WAIT) && a_have && b_have;
            nxt_ready_vec[k] = (st_n == ST_WAIT) && a_have_n && b_have_n;
        end

        // Station state and operation code registers
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                st_q <= ST_FREE;
                op_q <= '0;
            end else begin
                st_q <= st_n;
                if (load) op_q <= alloc_op;
            end
        end

        assign op_arr[k] = op_q;

        // R9: a dispatched station does not become ready again until freed
        a_r9_issued_quiet: assert property (@(posedge clk) disable iff (!rst_n)
            (st_q == ST_ISSUED) |-> !ready_vec[k]);

        // R6: a station is ready only once both slots hold a value
        a_r6_ready_needs_both: assert property (@(posedge clk) disable iff (!rst_n)
            (disp_valid && disp_tag == ID) |-> (a_have && b_have));
    end

    rs_age_arb #(.N(NUM_ST)) u_arb (
        .clk       (clk),
        .rst_n     (rst_n),
        .ready     (ready_vec),
        .nxt_ready (nxt_ready_vec),
        .fire      (disp_fire),
        .grant     (grant),
        .any       (grant_any)
    );

    // Dispatch mux: the granted station drives the offer
    always_comb begin
        disp_valid = grant_any;
        disp_op    = '0;
        disp_tag   = '0;
        disp_a     = '0;
        disp_b     = '0;
        for (int k = 0; k < NUM_ST; k++) begin
            if (grant[k]) begin
                disp_op  = op_arr[k];
                disp_tag = TAG_W'(BASE_TAG + k);
                disp_a   = a_arr[k];
                disp_b   = b_arr[k];
            end
        end
    end

    // R10: an offer not taken stays unchanged
    a_r10_hold_offer: assert property (@(posedge clk) disable iff (!rst_n)
        (disp_valid && !disp_ready) |=> (disp_valid && $stable(disp_tag)
            && $stable(disp_op) && $stable(disp_a) && $stable(disp_b)));

    // R9: an accepted station is not offered on the next cycle
    a_r9_no_repeat: assert property (@(posedge clk) disable iff (!rst_n)
        (disp_valid && disp_ready) |=> (!disp_valid || disp_tag != $past(disp_tag)));

    // R2: a full pool stays full until some result is broadcast
    a_r2_full_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (full && !bus_valid) |=> full);

endmodule

// File: tb/tb_rs_pool.sv
// Bench tb_rs_pool: directed scenarios on a three-station pool, base tag 10.
module tb_rs_pool;
    localparam int NUM_ST = 3;
    localparam int TAG_W  = 4;
    localparam int DATA_W = 16;
    localparam int OP_W   = 4;
    localparam int BASE   = 10;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              alloc_valid = 1'b0;
    logic [OP_W-1:0]   alloc_op = '0;
    logic              alloc_a_wait = 1'b0;
    logic [TAG_W-1:0]  alloc_a_tag = '0;
    logic [DATA_W-1:0] alloc_a_data = '0;
    logic              alloc_b_wait = 1'b0;
    logic [TAG_W-1:0]  alloc_b_tag = '0;
    logic [DATA_W-1:0] alloc_b_data = '0;
    logic              full;
    logic [TAG_W-1:0]  alloc_tag;
    logic              bus_valid = 1'b0;
    logic [TAG_W-1:0]  bus_tag = '0;
    logic [DATA_W-1:0] bus_data = '0;
    logic              disp_valid;
    logic              disp_ready = 1'b0;
    logic [OP_W-1:0]   disp_op;
    logic [TAG_W-1:0]  disp_tag;
    logic [DATA_W-1:0] disp_a;
    logic [DATA_W-1:0] disp_b;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #2.5 clk = ~clk;

    rs_pool #(
        .NUM_ST(NUM_ST), .TAG_W(TAG_W), .DATA_W(DATA_W),
        .OP_W(OP_W), .BASE_TAG(BASE)
    ) dut (
        .clk(clk), .rst_n(rst_n),
        .alloc_valid(alloc_valid), .alloc_op(alloc_op),
        .alloc_a_wait(alloc_a_wait), .alloc_a_tag(alloc_a_tag), .alloc_a_data(alloc_a_data),
        .alloc_b_wait(alloc_b_wait), .alloc_b_tag(alloc_b_tag), .alloc_b_data(alloc_b_data),
        .full(full), .alloc_tag(alloc_tag),
        .bus_valid(bus_valid), .bus_tag(bus_tag), .bus_data(bus_data),
        .disp_valid(disp_valid), .disp_ready(disp_ready), .disp_op(disp_op),
        .disp_tag(disp_tag), .disp_a(disp_a), .disp_b(disp_b)
    );

    // Compare one observed value against its expectation
    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: got %0h expected %0h", req, act, exp);
        end
    endtask

    // Advance one clock, then clear single-cycle inputs; outputs sampled after
    task automatic step();
        @(posedge clk);
        #1;
        alloc_valid = 1'b0;
        bus_valid   = 1'b0;
        disp_ready  = 1'b0;
    endtask

    task automatic put(input logic [3:0] op, input logic aw, input logic [3:0] at,
                       input logic [15:0] ad, input logic bw, input logic [3:0] bt,
                       input logic [15:0] bd);
        alloc_valid  = 1'b1;
        alloc_op     = op;
        alloc_a_wait = aw;
        alloc_a_tag  = at;
        alloc_a_data = ad;
        alloc_b_wait = bw;
        alloc_b_tag  = bt;
        alloc_b_data = bd;
    endtask

    task automatic bcast(input logic [3:0] t, input logic [15:0] d);
        bus_valid = 1'b1;
        bus_tag   = t;
        bus_data  = d;
    endtask

    // R11 reset state
    task automatic t_reset();
        chk("R11 full", 32'(full), 0);
        chk("R11 disp_valid", 32'(disp_valid), 0);
        chk("R11 alloc_tag", 32'(alloc_tag), BASE);
    endtask

    // R3 R6 R9 R10: both operands as values, hold then accept, release
    task automatic t_values();
        put(4'h3, 0, 0, 16'h0011, 0, 0, 16'h0022);
        step();
        chk("R6 ready next cycle", 32'(disp_valid), 1);
        chk("R1 disp_tag", 32'(disp_tag), BASE);
        chk("R3 disp_a", 32'(disp_a), 16'h0011);
        chk("R3 disp_b", 32'(disp_b), 16'h0022);
        chk("R3 disp_op", 32'(disp_op), 3);
        chk("R1 alloc_tag moves on", 32'(alloc_tag), BASE + 1);
        step();
        chk("R10 hold valid", 32'(disp_valid), 1);
        chk("R10 hold tag", 32'(disp_tag), BASE);
        chk("R10 hold a", 32'(disp_a), 16'h0011);
        disp_ready = 1'b1;
        step();
        chk("R9 not offered again", 32'(disp_valid), 0);
        chk("R9 still busy", 32'(alloc_tag), BASE + 1);
        bcast(4'(BASE), 16'hdead);
        step();
        chk("R9 freed by own broadcast", 32'(alloc_tag), BASE);
    endtask

    // R4: snoop ignores a foreign tag, captures the owed one
    task automatic t_snoop();
        put(4'h5, 1, 4'd3, 16'h0, 0, 0, 16'h0B0B);
        step();
        chk("R6 not ready while owed", 32'(disp_valid), 0);
        bcast(4'd4, 16'h4444);
        step();
        chk("R4 foreign tag ignored", 32'(disp_valid), 0);
        bcast(4'd3, 16'h00AB);
        step();
        chk("R4 captured", 32'(disp_valid), 1);
        chk("R4 captured data", 32'(disp_a), 16'h00AB);
        chk("R3 source kept", 32'(disp_b), 16'h0B0B);
        disp_ready = 1'b1;
        step();
        bcast(4'(BASE), 16'h0);
        step();
    endtask

    // R5: broadcast in the allocation cycle
    task automatic t_same_cycle();
        put(4'h6, 0, 0, 16'h0A0A, 1, 4'd5, 16'h0);
        bcast(4'd5, 16'h0055);
        step();
        chk("R5 ready", 32'(disp_valid), 1);
        chk("R5 data kept", 32'(disp_b), 16'h0055);
        disp_ready = 1'b1;
        step();
        bcast(4'(BASE), 16'h0);
        step();
    endtask

    // R1 R2 R7: fill the pool, refuse while full, ready-order dispatch
    task automatic t_full_order();
        chk("R1 first target", 32'(alloc_tag), BASE);
        put(4'h1, 1, 4'd1, 0, 0, 0, 16'h0001);
        step();
        chk("R1 second target", 32'(alloc_tag), BASE + 1);
        put(4'h2, 1, 4'd2, 0, 0, 0, 16'h0002);
        step();
        chk("R1 third target", 32'(alloc_tag), BASE + 2);
        chk("R2 not yet full", 32'(full), 0);
        put(4'h3, 1, 4'd3, 0, 0, 0, 16'h0003);
        step();
        chk("R2 full", 32'(full), 1);
        put(4'h9, 0, 0, 16'h9999, 0, 0, 16'h9999);
        step();
        chk("R2 refused alloc", 32'(disp_valid), 0);
        chk("R2 still full", 32'(full), 1);
        bcast(4'd3, 16'h0033);
        step();
        chk("R7 first ready", 32'(disp_tag), BASE + 2);
        bcast(4'd1, 16'h0031);
        step();
        chk("R7 earliest ahead of lower id", 32'(disp_tag), BASE + 2);
        disp_ready = 1'b1;
        step();
        chk("R7 next offer", 32'(disp_tag), BASE);
        chk("R4 capture after wait", 32'(disp_a), 16'h0031);
        disp_ready = 1'b1;
        step();
        chk("R9 none left ready", 32'(disp_valid), 0);
        bcast(4'd2, 16'h0032);
        step();
        chk("R7 last station", 32'(disp_tag), BASE + 1);
        disp_ready = 1'b1;
        step();
        for (int k = 0; k < NUM_ST; k++) begin
            bcast(4'(BASE + k), 16'h0);
            step();
        end
        chk("R2 drained", 32'(full), 0);
        chk("R1 lowest free again", 32'(alloc_tag), BASE);
    endtask

    // R8: two stations released by one broadcast
    task automatic t_tie();
        put(4'h7, 1, 4'd6, 0, 0, 0, 16'h0070);
        step();
        put(4'h8, 1, 4'd6, 0, 0, 0, 16'h0080);
        step();
        bcast(4'd6, 16'h0066);
        step();
        chk("R8 lowest id first", 32'(disp_tag), BASE);
        chk("R8 op of first", 32'(disp_op), 7);
        disp_ready = 1'b1;
        step();
        chk("R8 then next", 32'(disp_tag), BASE + 1);
        chk("R8 shared capture", 32'(disp_a), 16'h0066);
        disp_ready = 1'b1;
        step();
        chk("R9 empty offer", 32'(disp_valid), 0);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1;
        rst_n = 1'b1;
        t_reset();
        t_values();
        t_snoop();
        t_same_cycle();
        t_full_order();
        t_tie();
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    // Watchdog: a hung run counts as a failure
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end
endmodule